// File: doc/BRIEF.md
# Charge-Transfer Burst and Ramp Timer

This block runs one acquisition for a single key of a capacitive touch matrix. On a start request it drives a train of X pulses whose number comes from the key's burst-length setting. The Y line is released while X is high, so charge moves into the sample capacitor. It is clamped while X is low, so the electrode charge can settle before the next pulse.

After the final pulse the Y clamp stays on and the external ramp is enabled. The block counts clock cycles until a comparator reports the zero crossing. That elapsed count is the key's raw signal value. If no crossing arrives before a ceiling is reached, the count saturates and a timeout flag is raised. Completion is marked by a one-cycle done pulse. In that same cycle every drive output returns to its idle level.

The comparator input is asynchronous to the block and passes through a two-flop synchronizer. High time, low time, count width and the ceiling are parameters.

Top module: `ctburst_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is low and the count is zero.
- R2: A start sampled in idle with burst length N>0 makes X go high in the next cycle. X then produces exactly N pulses, each high for HI_CYC cycles and followed by LO_CYC low cycles.
- R3: During the burst, the Y clamp is high in exactly the cycles where X is low. X and the clamp are never high together.
- R4: After the last low phase, the clamp stays high with no gap and the ramp enable turns on in the next cycle.
- R5: The ramp enable is high only during measurement, and X is low and the clamp high throughout it.
- R6: The count reported equals the number of measurement cycles that pass before the synchronized comparator is seen high. The comparator reaches the control logic two cycles after it changes. The ramp ends in the cycle done rises.
- R7: If the count reaches MAX_COUNT with no crossing, the block finishes with count MAX_COUNT and timeout=1. Otherwise timeout=0.
- R8: Done is high for exactly one cycle. In that cycle count and timeout take their new values, and X, clamp and ramp are all low.
- R9: A start seen while a run is in progress, including its done cycle, has no effect.
- R10: A burst length of 0 skips the pulse train. The cycle after start goes straight to measurement with clamp and ramp high.
- R11: The comparator is ignored outside the measurement phase.
- R12: Count and timeout hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an acquisition (used only in idle) |
| burst_len_i | input | BL_W | Number of X pulses in the burst |
| zc_i | input | 1 | Asynchronous comparator, high at zero crossing |
| xdrv_o | output | 1 | X pulse drive |
| yclamp_o | output | 1 | Y line clamp to ground |
| ramp_en_o | output | 1 | External ramp enable |
| count_o | output | CNT_W | Measured zero-crossing time in cycles |
| timeout_o | output | 1 | Count saturated without crossing |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A phase counter that slips shows up within one pulse as an X edge one cycle early or late, against a model that lists every expected drive cycle. A pulse counter that is off by one adds or drops a whole HI_CYC+LO_CYC window before the ramp turns on. A synchronizer with the wrong depth, or a measurement counter that starts at the wrong value, moves the reported count by one, and this is seen in the done cycle. A state machine that leaves the busy state too early lets a second start or a stray comparator edge change the drive pattern within a cycle or two.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_XHI  = 3'd1,
    ST_XLO  = 3'd2,
    ST_MEAS = 3'd3,
    ST_DONE = 3'd4
  } ctb_state_t;
endpackage

// File: rtl/ctb_sync.sv
module ctb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ctb_phase_timer.sv
module ctb_phase_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)             left_q <= '0;
    else if (load_i)     left_q <= load_val_i;
    else if (left_q != 0) left_q <= left_q - W'(1);
  end

  assign zero_o = (left_q == '0);
endmodule

// File: rtl/ctb_ramp_count.sv
module ctb_ramp_count #(
  parameter int CNT_W     = 12,
  parameter int MAX_COUNT = 4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] CEIL = CNT_W'(MAX_COUNT);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (inc_i && cnt_q != CEIL) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == CEIL);
endmodule

// File: rtl/ctburst_timer.sv
module ctburst_timer
  import ctb_pkg::*;
#(
  parameter int BL_W      = 8,
  parameter int HI_CYC    = 4,
  parameter int LO_CYC    = 4,
  parameter int CNT_W     = 12,
  parameter int MAX_COUNT = 4000,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [BL_W-1:0]  burst_len_i,
  input  logic             zc_i,
  output logic             xdrv_o,
  output logic             yclamp_o,
  output logic             ramp_en_o,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o,
  output logic             done_o
);
  localparam int PH_MAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam logic [PH_W-1:0] HI_LOAD = PH_W'(HI_CYC - 1);
  localparam logic [PH_W-1:0] LO_LOAD = PH_W'(LO_CYC - 1);

  ctb_state_t       state_q, state_d;
  logic [BL_W-1:0]  pulses_q, pulses_d;
  logic             ph_load;
  logic [PH_W-1:0]  ph_val;
  logic             ph_zero;
  logic             zc_s;
  logic             m_clr, m_inc, m_max;
  logic [CNT_W-1:0] m_cnt;
  logic             cap_en, cap_to;

  ctb_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_i(zc_i), .q_o(zc_s)
  );

  ctb_phase_timer #(.W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .load_i(ph_load), .load_val_i(ph_val), .zero_o(ph_zero)
  );

  ctb_ramp_count #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_meas (
    .clk(clk), .rst(rst), .clr_i(m_clr), .inc_i(m_inc),
    .cnt_o(m_cnt), .at_max_o(m_max)
  );

  always_comb begin
    state_d  = state_q;
    pulses_d = pulses_q;
    ph_load  = 1'b0;
    ph_val   = HI_LOAD;
    m_clr    = 1'b0;
    m_inc    = 1'b0;
    cap_en   = 1'b0;
    cap_to   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (burst_len_i == '0) begin
            state_d = ST_MEAS;
            m_clr   = 1'b1;
          end else begin
            state_d  = ST_XHI;
            pulses_d = burst_len_i;
            ph_load  = 1'b1;
            ph_val   = HI_LOAD;
          end
        end
      end
      ST_XHI: begin
        if (ph_zero) begin
          state_d = ST_XLO;
          ph_load = 1'b1;
          ph_val  = LO_LOAD;
        end
      end
      ST_XLO: begin
        if (ph_zero) begin
          if (pulses_q == BL_W'(1)) begin
            state_d = ST_MEAS;
            m_clr   = 1'b1;
          end else begin
            state_d  = ST_XHI;
            pulses_d = pulses_q - BL_W'(1);
            ph_load  = 1'b1;
            ph_val   = HI_LOAD;
          end
        end
      end
      ST_MEAS: begin
        if (zc_s) begin
          state_d = ST_DONE;
          cap_en  = 1'b1;
        end else if (m_max) begin
          state_d = ST_DONE;
          cap_en  = 1'b1;
          cap_to  = 1'b1;
        end else begin
          m_inc = 1'b1;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pulses_q  <= '0;
      xdrv_o    <= 1'b0;
      yclamp_o  <= 1'b0;
      ramp_en_o <= 1'b0;
      done_o    <= 1'b0;
      count_o   <= '0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      pulses_q  <= pulses_d;
      xdrv_o    <= (state_d == ST_XHI);
      yclamp_o  <= (state_d == ST_XLO) || (state_d == ST_MEAS);
      ramp_en_o <= (state_d == ST_MEAS);
      done_o    <= (state_d == ST_DONE);
      if (cap_en) begin
        count_o   <= m_cnt;
        timeout_o <= cap_to;
      end
    end
  end
endmodule

// File: rtl/ctb_checker.sv
module ctb_checker #(
  parameter int CNT_W     = 12,
  parameter int MAX_COUNT = 4000
) (
  input logic             clk,
  input logic             rst,
  input logic             xdrv_o,
  input logic             yclamp_o,
  input logic             ramp_en_o,
  input logic [CNT_W-1:0] count_o,
  input logic             timeout_o,
  input logic             done_o
);
  assert_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(xdrv_o && yclamp_o));

  assert_xfall_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(xdrv_o) |-> yclamp_o);

  assert_ramp_drive_R5: assert property (@(posedge clk) disable iff (rst)
    ramp_en_o |-> (yclamp_o && !xdrv_o));

  assert_ramp_end_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(ramp_en_o) |-> done_o);

  assert_sat_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (count_o == CNT_W'(MAX_COUNT)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!xdrv_o && !yclamp_o && !ramp_en_o));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(count_o) && $stable(timeout_o)));
endmodule

bind ctburst_timer ctb_checker #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_chk (
  .clk(clk), .rst(rst), .xdrv_o(xdrv_o), .yclamp_o(yclamp_o),
  .ramp_en_o(ramp_en_o), .count_o(count_o), .timeout_o(timeout_o),
  .done_o(done_o)
);

// File: tb/sim_ctburst_timer.sv
module sim_ctburst_timer;
  localparam int BL_W = 5, HI = 3, LO = 2, CNT_W = 8, MAXC = 40;

  logic clk = 1'b0, rst = 1'b1, start_i = 1'b0, zc_i = 1'b0;
  logic [BL_W-1:0] burst_len_i = '0;
  logic xdrv_o, yclamp_o, ramp_en_o, timeout_o, done_o;
  logic [CNT_W-1:0] count_o;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ctburst_timer #(.BL_W(BL_W), .HI_CYC(HI), .LO_CYC(LO), .CNT_W(CNT_W),
                  .MAX_COUNT(MAXC), .SYNC_STG(2)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .burst_len_i(burst_len_i),
    .zc_i(zc_i), .xdrv_o(xdrv_o), .yclamp_o(yclamp_o), .ramp_en_o(ramp_en_o),
    .count_o(count_o), .timeout_o(timeout_o), .done_o(done_o));

  // Behavioural reference model
  int mode = 0;            // 0 idle, 1 burst, 2 measure, 3 done
  int seq[$];              // 1 = X high cycle, 2 = clamp cycle
  int mcnt = 0;
  bit z1 = 0, z2 = 0, zu;
  bit e_x = 0, e_c = 0, e_r = 0, e_d = 0, e_to = 0, model_ok = 0;
  int e_cnt = 0;

  task automatic enter_meas();
    mode = 2; mcnt = 0; e_x = 0; e_c = 1; e_r = 1;
  endtask

  always @(posedge clk) begin
    model_ok = 1;
    if (rst) begin
      mode = 0; seq.delete(); mcnt = 0; z1 = 0; z2 = 0;
      e_x = 0; e_c = 0; e_r = 0; e_d = 0; e_to = 0; e_cnt = 0;
    end else begin
      zu = z2; z2 = z1; z1 = zc_i;
      case (mode)
        0: begin
          e_d = 0;
          if (start_i) begin
            for (int p = 0; p < int'(burst_len_i); p++) begin
              for (int h = 0; h < HI; h++) seq.push_back(1);
              for (int l = 0; l < LO; l++) seq.push_back(2);
            end
            if (seq.size() == 0) enter_meas();
            else begin
              int v; v = seq.pop_front();
              mode = 1; e_x = (v == 1); e_c = (v == 2); e_r = 0;
            end
          end
        end
        1: begin
          if (seq.size() == 0) enter_meas();
          else begin
            int v; v = seq.pop_front();
            e_x = (v == 1); e_c = (v == 2);
          end
        end
        2: begin
          if (zu) begin
            e_cnt = mcnt; e_to = 0; e_d = 1; mode = 3;
            e_x = 0; e_c = 0; e_r = 0;
          end else if (mcnt == MAXC) begin
            e_cnt = MAXC; e_to = 1; e_d = 1; mode = 3;
            e_x = 0; e_c = 0; e_r = 0;
          end else mcnt++;
        end
        default: begin e_d = 0; mode = 0; end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (model_ok && !finished) begin
      chk(xdrv_o == e_x, rst ? "R1 xdrv" : "R2 xdrv", xdrv_o, e_x);
      chk(yclamp_o == e_c, rst ? "R1 clamp" : "R3/R4 clamp", yclamp_o, e_c);
      chk(ramp_en_o == e_r, rst ? "R1 ramp" : "R5 ramp", ramp_en_o, e_r);
      chk(int'(count_o) == e_cnt, rst ? "R1 count" : "R6/R12 count", count_o, e_cnt);
      chk(timeout_o == e_to, rst ? "R1 timeout" : "R7 timeout", timeout_o, e_to);
      chk(done_o == e_d, rst ? "R1 done" : "R8 done", done_o, e_d);
    end
    if (cyc > 50000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // len: pulses; k: cycles after ramp seen before comparator rises (<0: never)
  // extra: pulse start during run (R9); stray: comparator blip in burst (R11)
  task automatic run(input int len, input int k, input bit extra, input bit stray);
    @(negedge clk);
    burst_len_i = BL_W'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (stray && len > 1) begin
      @(negedge clk); zc_i = 1'b1;
      @(negedge clk); zc_i = 1'b0;
    end
    if (extra) begin
      @(negedge clk); start_i = 1'b1; burst_len_i = BL_W'(1);
      @(negedge clk); start_i = 1'b0;
    end
    while (!ramp_en_o) @(negedge clk);
    if (k >= 0) begin
      repeat (k) @(negedge clk);
      zc_i = 1'b1;
    end
    while (!done_o) @(negedge clk);
    if (extra) start_i = 1'b1;       // R9: start in done cycle ignored
    @(negedge clk);
    start_i = 1'b0; zc_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);      // R1 checked during reset
    rst = 1'b0;
    repeat (2) @(negedge clk);
    run(3, 10, 0, 0);               // R2 R3 R4 R6
    run(1, 0, 0, 0);                // R6 minimum count
    run(0, 5, 0, 0);                // R10 no burst
    run(4, -1, 0, 0);               // R7 timeout saturates
    run(2, 7, 0, 0);                // R7 timeout clears
    run(3, 38, 0, 0);               // R6 near ceiling
    run(4, 3, 1, 1);                // R9 R11
    run(31, 2, 0, 0);               // R2 longest burst
    repeat (5) @(negedge clk);      // R12 hold in idle
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule